// File: doc/BRIEF.md
# Condition Register and Branch Evaluator

This block keeps the condition state and the loop counter that a processor's branch logic consults. The condition state is a 32-bit register divided into eight 4-bit fields, and each field can be written on its own by a compare. Two single condition bits can also be combined with AND into a third bit. Beside it sits a 64-bit count register. Software loads the count register directly, and conditional branches step it down.

One operation is presented per cycle on `op_valid`/`op_code`. A branch evaluation can decrement the count and test the new value for zero or for non-zero. It can also require one chosen condition bit to be 1 or to be 0. It can do both, or neither. The outcome appears as a one-cycle `br_valid` pulse carrying `br_taken`. Decoding, target address generation and return-address storage belong to neighbouring blocks.

All state and outputs are registered. The effect of an operation presented in one cycle is visible on the outputs after the next rising clock edge. Reset is asserted asynchronously and released in step with the clock.

Top module: `crb_unit`

## Requirements
- R1: While reset is held and after it is released, `cr_out` is 0, `ctr_out` is 0 and `br_valid` is 0 until an operation is applied.
- R2: A compare (`op_code` 0) writes field `fld_sel` one cycle later. Field f occupies `cr_out[31-4f -: 4]`, and its bits from most significant down are less-than, greater-than, equal and overflow-summary. The compare is of `src_a` against `src_b`, two's-complement when `cmp_signed` is 1 and unsigned when it is 0. Exactly one of the upper three bits of the field is set.
- R3: A compare copies `ovf_sticky` into the overflow-summary bit of the written field and leaves the other seven fields unchanged.
- R4: A condition-AND (`op_code` 1) writes `cr[bit_a] & cr[bit_b]` into `cr[bit_d]` and leaves every other bit unchanged. A bit index k names `cr_out[31-k]`, so field f bit j (0 = less-than) has index 4f+j.
- R5: A count move (`op_code` 2) loads `src_a` into `ctr_out` one cycle later and leaves `cr_out` unchanged.
- R6: A branch (`op_code` 3) with `br_use_ctr` = 1 decrements the count by one, wrapping at zero. Its count test uses the decremented value: the test requires zero when `br_ctr_zero` is 1 and non-zero when it is 0.
- R7: A branch with `br_use_bit` = 1 requires condition bit `br_bit_sel` (indexed as in R4) to equal `br_bit_val`.
- R8: When both tests are enabled, the branch is taken only if both hold. With neither enabled, the branch is always taken.
- R9: `br_valid` is 1 for exactly the cycle after each branch, with `br_taken` valid in that cycle. The count changes only on a count move or on a branch with `br_use_ctr` = 1.
- R10: While `op_valid` is 0, neither `cr_out` nor `ctr_out` changes and `br_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| op_valid | input | 1 | An operation is present this cycle |
| op_code | input | 2 | 0 compare, 1 condition-AND, 2 count move, 3 branch |
| cmp_signed | input | 1 | Compare as two's-complement when 1 |
| src_a | input | 64 | First compare operand, or count load value |
| src_b | input | 64 | Second compare operand |
| fld_sel | input | 3 | Field written by a compare |
| ovf_sticky | input | 1 | Sticky overflow copied into the compare field |
| bit_a | input | 5 | First AND source bit index |
| bit_b | input | 5 | Second AND source bit index |
| bit_d | input | 5 | AND destination bit index |
| br_use_ctr | input | 1 | Branch decrements and tests the count |
| br_ctr_zero | input | 1 | Count test requires zero (1) or non-zero (0) |
| br_use_bit | input | 1 | Branch tests a condition bit |
| br_bit_sel | input | 5 | Index of the tested condition bit |
| br_bit_val | input | 1 | Required value of the tested bit |
| cr_out | output | 32 | Condition register |
| ctr_out | output | 64 | Count register |
| br_valid | output | 1 | Branch outcome valid |
| br_taken | output | 1 | Branch outcome |

## Verification
The assertions assume that control inputs are at known values whenever `op_valid` is 1, and that no operation arrives during the reset-release window. The bench meets both conditions. It drives every input to a defined idle value at all times and waits several cycles after releasing reset before its first operation. The assertions also assume one operation per cycle, decoded only from `op_code`. The bench therefore drops `op_valid` between operations. In one idle check it leaves misleading values on the other inputs, to show that they have no effect without `op_valid`.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int unsigned FW = 4;

  typedef enum logic [1:0] {
    OP_CMP  = 2'd0,
    OP_CAND = 2'd1,
    OP_MTC  = 2'd2,
    OP_BR   = 2'd3
  } crb_op_e;
endpackage

// File: rtl/crb_compare.sv
module crb_compare #(
  parameter int unsigned DW = 64
) (
  input  logic [DW-1:0]          a,
  input  logic [DW-1:0]          b,
  input  logic                   signed_mode,
  input  logic                   ovf,
  output logic [crb_pkg::FW-1:0] fld
);
  logic lt, gt, eq;

  always_comb begin
    eq = (a == b);
    if (signed_mode) begin
      lt = ($signed(a) < $signed(b));
    end else begin
      lt = (a < b);
    end
    gt = !lt && !eq;
    fld = {lt, gt, eq, ovf};
  end
endmodule

// File: rtl/crb_cr_file.sv
module crb_cr_file #(
  parameter int unsigned NF = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_cmp,
  input  logic [$clog2(NF)-1:0]       cmp_sel,
  input  logic [crb_pkg::FW-1:0]      cmp_fld,
  input  logic                        wr_bit,
  input  logic [$clog2(NF*crb_pkg::FW)-1:0] bit_a,
  input  logic [$clog2(NF*crb_pkg::FW)-1:0] bit_b,
  input  logic [$clog2(NF*crb_pkg::FW)-1:0] bit_d,
  input  logic [$clog2(NF*crb_pkg::FW)-1:0] rd_sel,
  output logic                        rd_bit,
  output logic [NF*crb_pkg::FW-1:0]   cr_q
);
  localparam int unsigned FW  = crb_pkg::FW;
  localparam int unsigned CRW = NF * FW;
  localparam int unsigned BW  = $clog2(CRW);
  localparam int unsigned SW  = $clog2(NF);
  localparam int unsigned FB  = $clog2(FW);

  logic [CRW-1:0] cr_rev;
  logic           and_val;
  logic [FW-1:0]  fld_q   [NF];
  logic [FW-1:0]  fld_nxt [NF];
  logic [NF-1:0]  fld_en;

  assign and_val = cr_rev[bit_a] & cr_rev[bit_b];
  assign rd_bit  = cr_rev[rd_sel];

  for (genvar f = 0; f < NF; f++) begin : g_fld
    assign cr_q[CRW-1-FW*f -: FW] = fld_q[f];
    for (genvar j = 0; j < FW; j++) begin : g_rev
      assign cr_rev[FW*f+j] = fld_q[f][FW-1-j];
    end

    always_comb begin
      fld_en[f] = (wr_cmp && (cmp_sel == SW'(f))) ||
                  (wr_bit && (bit_d[BW-1:FB] == SW'(f)));
      fld_nxt[f] = (wr_cmp && (cmp_sel == SW'(f))) ? cmp_fld : fld_q[f];
      for (int j = 0; j < FW; j++) begin
        if (wr_bit && (bit_d == BW'(f*FW+j))) begin
          fld_nxt[f][FW-1-j] = and_val;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fld_q[f] <= '0;
      end else if (fld_en[f]) begin
        fld_q[f] <= fld_nxt[f];
      end
    end
  end
endmodule

// File: rtl/crb_branch.sv
module crb_branch #(
  parameter int unsigned DW = 64
) (
  input  logic [DW-1:0] ctr_q,
  input  logic          cr_bit,
  input  logic          use_ctr,
  input  logic          need_zero,
  input  logic          use_bit,
  input  logic          bit_val,
  output logic [DW-1:0] ctr_dec,
  output logic          taken
);
  logic ctr_ok, bit_ok;

  always_comb begin
    ctr_dec = ctr_q - DW'(1);
    ctr_ok  = need_zero ? (ctr_dec == '0) : (ctr_dec != '0);
    bit_ok  = (cr_bit == bit_val);
    taken   = (!use_ctr || ctr_ok) && (!use_bit || bit_ok);
  end
endmodule

// File: rtl/crb_unit.sv
module crb_unit #(
  parameter int unsigned NF = 8,
  parameter int unsigned DW = 64
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                op_valid,
  input  logic [1:0]                          op_code,
  input  logic                                cmp_signed,
  input  logic [DW-1:0]                       src_a,
  input  logic [DW-1:0]                       src_b,
  input  logic [$clog2(NF)-1:0]               fld_sel,
  input  logic                                ovf_sticky,
  input  logic [$clog2(NF*crb_pkg::FW)-1:0]   bit_a,
  input  logic [$clog2(NF*crb_pkg::FW)-1:0]   bit_b,
  input  logic [$clog2(NF*crb_pkg::FW)-1:0]   bit_d,
  input  logic                                br_use_ctr,
  input  logic                                br_ctr_zero,
  input  logic                                br_use_bit,
  input  logic [$clog2(NF*crb_pkg::FW)-1:0]   br_bit_sel,
  input  logic                                br_bit_val,
  output logic [NF*crb_pkg::FW-1:0]           cr_out,
  output logic [DW-1:0]                       ctr_out,
  output logic                                br_valid,
  output logic                                br_taken
);
  import crb_pkg::*;

  logic [1:0]    rst_sync;
  logic          rst_int_n;
  crb_op_e       op;
  logic          is_cmp, is_cand, is_mtc, is_br;
  logic [FW-1:0] cmp_fld;
  logic          sel_bit;
  logic [DW-1:0] ctr_q, ctr_nxt, ctr_dec;
  logic          ctr_en;
  logic          taken_c;
  logic          bv_q, bt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  always_comb begin
    op      = crb_op_e'(op_code);
    is_cmp  = op_valid && (op == OP_CMP);
    is_cand = op_valid && (op == OP_CAND);
    is_mtc  = op_valid && (op == OP_MTC);
    is_br   = op_valid && (op == OP_BR);
  end

  crb_compare #(.DW(DW)) i_cmp (
    .a           (src_a),
    .b           (src_b),
    .signed_mode (cmp_signed),
    .ovf         (ovf_sticky),
    .fld         (cmp_fld)
  );

  crb_cr_file #(.NF(NF)) i_crf (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_cmp  (is_cmp),
    .cmp_sel (fld_sel),
    .cmp_fld (cmp_fld),
    .wr_bit  (is_cand),
    .bit_a   (bit_a),
    .bit_b   (bit_b),
    .bit_d   (bit_d),
    .rd_sel  (br_bit_sel),
    .rd_bit  (sel_bit),
    .cr_q    (cr_out)
  );

  crb_branch #(.DW(DW)) i_br (
    .ctr_q     (ctr_q),
    .cr_bit    (sel_bit),
    .use_ctr   (br_use_ctr),
    .need_zero (br_ctr_zero),
    .use_bit   (br_use_bit),
    .bit_val   (br_bit_val),
    .ctr_dec   (ctr_dec),
    .taken     (taken_c)
  );

  always_comb begin
    ctr_en  = is_mtc || (is_br && br_use_ctr);
    ctr_nxt = is_mtc ? src_a : ctr_dec;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctr_q <= '0;
    end else if (ctr_en) begin
      ctr_q <= ctr_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      bv_q <= 1'b0;
      bt_q <= 1'b0;
    end else begin
      bv_q <= is_br;
      if (is_br) begin
        bt_q <= taken_c;
      end
    end
  end

  assign ctr_out  = ctr_q;
  assign br_valid = bv_q;
  assign br_taken = bt_q;
endmodule

// File: rtl/crb_unit_chk.sv
module crb_unit_chk #(
  parameter int unsigned NF = 8,
  parameter int unsigned DW = 64
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      op_valid,
  input logic [1:0]                op_code,
  input logic [$clog2(NF)-1:0]     fld_sel,
  input logic                      ovf_sticky,
  input logic                      br_use_ctr,
  input logic                      br_use_bit,
  input logic [NF*crb_pkg::FW-1:0] cr_out,
  input logic [DW-1:0]             ctr_out,
  input logic                      br_valid,
  input logic                      br_taken
);
  localparam int unsigned FW  = crb_pkg::FW;
  localparam int unsigned CRW = NF * FW;
  localparam int unsigned SW  = $clog2(NF);

  for (genvar f = 0; f < NF; f++) begin : g_chk
    p_cmp_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 2'd0 && fld_sel == SW'(f))
      |=> ($countones(cr_out[CRW-1-FW*f -: 3]) == 1));

    p_cmp_so_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 2'd0 && fld_sel == SW'(f))
      |=> (cr_out[CRW-FW*(f+1)] == $past(ovf_sticky)));

    p_cmp_other_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == 2'd0 && fld_sel != SW'(f))
      |=> $stable(cr_out[CRW-1-FW*f -: FW]));
  end

  p_ctr_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'd3 && br_use_ctr)
    |=> (ctr_out == $past(ctr_out) - DW'(1)));

  p_uncond_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 2'd3 && !br_use_ctr && !br_use_bit)
    |=> (br_valid && br_taken));

  p_brvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_code == 2'd3) |=> !br_valid);

  p_ctr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && (op_code == 2'd2 || (op_code == 2'd3 && br_use_ctr)))
    |=> $stable(ctr_out));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(cr_out) && $stable(ctr_out)));
endmodule

bind crb_unit crb_unit_chk #(.NF(NF), .DW(DW)) i_crb_unit_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .fld_sel    (fld_sel),
  .ovf_sticky (ovf_sticky),
  .br_use_ctr (br_use_ctr),
  .br_use_bit (br_use_bit),
  .cr_out     (cr_out),
  .ctr_out    (ctr_out),
  .br_valid   (br_valid),
  .br_taken   (br_taken)
);

// File: tb/test_crb_unit.sv
module test_crb_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [1:0]  op_code;
  logic        cmp_signed;
  logic [63:0] src_a, src_b;
  logic [2:0]  fld_sel;
  logic        ovf_sticky;
  logic [4:0]  bit_a, bit_b, bit_d;
  logic        br_use_ctr, br_ctr_zero, br_use_bit;
  logic [4:0]  br_bit_sel;
  logic        br_bit_val;
  logic [31:0] cr_out;
  logic [63:0] ctr_out;
  logic        br_valid, br_taken;

  int checks = 0;
  int errors = 0;
  logic [31:0] e_cr;
  logic [63:0] e_ctr;

  always #4 clk = ~clk;

  crb_unit i_crb_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .cmp_signed(cmp_signed), .src_a(src_a), .src_b(src_b),
    .fld_sel(fld_sel), .ovf_sticky(ovf_sticky), .bit_a(bit_a),
    .bit_b(bit_b), .bit_d(bit_d), .br_use_ctr(br_use_ctr),
    .br_ctr_zero(br_ctr_zero), .br_use_bit(br_use_bit),
    .br_bit_sel(br_bit_sel), .br_bit_val(br_bit_val), .cr_out(cr_out),
    .ctr_out(ctr_out), .br_valid(br_valid), .br_taken(br_taken)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    op_valid = 1'b0; op_code = 2'd0; cmp_signed = 1'b0;
    src_a = '0; src_b = '0; fld_sel = '0; ovf_sticky = 1'b0;
    bit_a = '0; bit_b = '0; bit_d = '0;
    br_use_ctr = 1'b0; br_ctr_zero = 1'b0; br_use_bit = 1'b0;
    br_bit_sel = '0; br_bit_val = 1'b0;
  endtask

  // drive at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic issue();
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 cr", {32'd0, cr_out}, 64'd0);
    chk("R1 ctr", ctr_out, 64'd0);
    chk("R1 br_valid", {63'd0, br_valid}, 64'd0);
  endtask

  task automatic t_cmp(input logic [63:0] a, input logic [63:0] b, input logic sg,
                       input int f, input logic ov);
    logic lt, eq;
    op_code = 2'd0; src_a = a; src_b = b; cmp_signed = sg;
    fld_sel = 3'(f); ovf_sticky = ov;
    issue();
    eq = (a == b);
    lt = sg ? ($signed(a) < $signed(b)) : (a < b);
    e_cr[31-4*f -: 4] = {lt, !lt && !eq, eq, ov};
    chk("R2 R3 compare field", {32'd0, cr_out}, {32'd0, e_cr});
    chk("R5 compare leaves count", ctr_out, e_ctr);
  endtask

  task automatic t_cand(input int a, input int b, input int d);
    op_code = 2'd1; bit_a = 5'(a); bit_b = 5'(b); bit_d = 5'(d);
    issue();
    e_cr[31-d] = e_cr[31-a] & e_cr[31-b];
    chk("R4 condition and", {32'd0, cr_out}, {32'd0, e_cr});
  endtask

  task automatic t_mtc(input logic [63:0] v);
    op_code = 2'd2; src_a = v;
    issue();
    e_ctr = v;
    chk("R5 count move", ctr_out, e_ctr);
    chk("R5 cr unchanged", {32'd0, cr_out}, {32'd0, e_cr});
  endtask

  task automatic t_br(input logic uc, input logic cz, input logic ub,
                      input int sel, input logic bv);
    logic        ok_c, ok_b, exp_t;
    logic [63:0] dec;
    op_code = 2'd3; br_use_ctr = uc; br_ctr_zero = cz; br_use_bit = ub;
    br_bit_sel = 5'(sel); br_bit_val = bv;
    dec   = e_ctr - 64'd1;
    ok_c  = cz ? (dec == 64'd0) : (dec != 64'd0);
    ok_b  = (e_cr[31-sel] == bv);
    exp_t = (!uc || ok_c) && (!ub || ok_b);
    if (uc) e_ctr = dec;
    issue();
    br_use_ctr = 1'b0; br_use_bit = 1'b0;
    chk("R9 br_valid pulse", {63'd0, br_valid}, 64'd1);
    chk("R6 R7 R8 br_taken", {63'd0, br_taken}, {63'd0, exp_t});
    chk("R6 R9 count after branch", ctr_out, e_ctr);
    @(negedge clk);
    chk("R9 br_valid drops", {63'd0, br_valid}, 64'd0);
  endtask

  task automatic t_idle_garbage();
    op_code = 2'd2; src_a = 64'hDEAD_BEEF_0000_0001; fld_sel = 3'd0;
    bit_d = 5'd0; br_use_ctr = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 cr unchanged", {32'd0, cr_out}, {32'd0, e_cr});
    chk("R10 ctr unchanged", ctr_out, e_ctr);
    chk("R10 no branch", {63'd0, br_valid}, 64'd0);
    idle_inputs();
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    e_cr = '0; e_ctr = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();

    t_cmp(64'd5, 64'd9, 1'b0, 0, 1'b0);
    t_cmp(-64'sd1, 64'd1, 1'b1, 7, 1'b1);
    t_cmp(-64'sd1, 64'd1, 1'b0, 3, 1'b0);
    t_cmp(64'd42, 64'd42, 1'b0, 5, 1'b1);
    t_cmp(64'd7, -64'sd3, 1'b1, 0, 1'b0);

    t_cand(1, 28, 2);
    t_cand(1, 29, 1);
    t_cand(31, 31, 8);

    t_mtc(64'd3);
    t_br(1'b1, 1'b0, 1'b0, 0, 1'b0);
    t_br(1'b1, 1'b0, 1'b0, 0, 1'b0);
    t_br(1'b1, 1'b0, 1'b0, 0, 1'b0);
    t_br(1'b1, 1'b1, 1'b0, 0, 1'b0);
    t_mtc(64'd1);
    t_br(1'b1, 1'b1, 1'b0, 0, 1'b0);

    t_br(1'b0, 1'b0, 1'b1, 2, 1'b1);
    t_br(1'b0, 1'b0, 1'b1, 2, 1'b0);
    t_mtc(64'd5);
    t_br(1'b1, 1'b0, 1'b1, 2, 1'b0);
    t_br(1'b1, 1'b0, 1'b1, 2, 1'b1);
    t_br(1'b0, 1'b0, 1'b0, 0, 1'b0);

    t_idle_garbage();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule